// File: doc/BRIEF.md
# Five-Port Mesh Tile Router

This block forwards flits for one tile of a two-dimensional on-chip mesh of 6 columns by 4 rows. It has five link ports (local tile, east, west, north, south). Every link carries a 128-bit data field and a 16-bit sideband. The router knows its own coordinates through parameters. Each input port has eight virtual channels (VCs), each with its own 4-flit buffer. The upstream sender selects the VC with `in_vc`.

A packet begins with a head flit whose sideband holds the destination. The router routes the head dimension-ordered: first along X, then along Y. It reserves an output port and a downstream VC of the packet's traffic class. Body and tail flits follow that reservation, and the tail frees the downstream VC when it leaves. Each output port chooses among the competing input VCs in round-robin order. Per-VC credit counters stop the router from overrunning downstream buffers, and the router returns a credit upstream for every flit that leaves one of its own buffers.

Sideband layout:

| Bits | Meaning |
|------|---------|
| bit 0 | tail |
| bit 1 | head |
| bits 4:2 | destination X |
| bits 6:5 | destination Y |
| bits 15:7 | free payload |

A flit with both bit 0 and bit 1 set is a single-flit packet. Port index order is 0 local, 1 east, 2 west, 3 north, 4 south. In every packed port array, slot `[p]` belongs to port `p`, and slot `[p][v]` belongs to VC `v` of that port.

Top module: `mesh_router`

## Requirements
- R1: Reset is synchronous and active low. While and after it, every `out_valid` and every `crd_ret` bit is 0, no buffered flit survives, and every downstream VC holds 4 credits.
- R2: When the head's destination X is larger than the router's own X, the packet leaves on east (port 1). When it is smaller, the packet leaves on west (port 2). This holds whatever the destination Y is.
- R3: When the destination X equals the router's own X, the packet leaves on north (port 3) if the destination Y is larger, on south (port 4) if it is smaller, and on local (port 0) if both coordinates match.
- R4: A head flit that meets no contention is accepted at clock edge k and is visible on its output after edge k+3. It is not visible after edge k+2.
- R5: VCs 0-3 form class 0 and VCs 4-7 form class 1. A packet gets the lowest-numbered free downstream VC of the class of the input VC it arrived on.
- R6: Body and tail flits leave on the port and VC that their head reserved, whatever their sideband destination bits say. They leave in arrival order, one per cycle when nothing blocks them.
- R7: A downstream VC stays reserved until its packet's tail flit has been sent. While it is reserved, other packets receive a different VC. After the tail has been sent, the VC can be given to the next packet.
- R8: The router sends at most 4 flits on a downstream VC without a matching `crd_in` pulse. Each pulse on `crd_in[o][v]` allows one more flit on VC `v` of output `o`.
- R9: For each flit that leaves input VC `v` of port `p`, `crd_ret[p][v]` is high for one cycle. That pulse comes one cycle before the flit appears on the output.
- R10: When input VCs compete for the same output port, they are served in round-robin order. Two packets streaming to one output interleave flit by flit.
- R11: Data and sideband reach the output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 5 | A flit is present on input port p |
| in_vc | input | 5x3 | VC the flit on port p is written into |
| in_data | input | 5x128 | Flit data per input port |
| in_sb | input | 5x16 | Flit sideband per input port |
| crd_ret | output | 5x8 | One-cycle credit pulse per input VC freed |
| out_valid | output | 5 | A flit is present on output port p |
| out_vc | output | 5x3 | Downstream VC of the outgoing flit |
| out_data | output | 5x128 | Flit data per output port |
| out_sb | output | 5x16 | Flit sideband per output port |
| crd_in | input | 5x8 | Credit pulses from downstream, per output VC |

## Verification
The bench uses the default parameters: coordinates (2,1) on the 6x4 mesh, 8 VCs and 4-flit buffers. Because the router sits inside the mesh, destinations exist on every side, so all five output ports and every routing branch can be reached. The 4-flit depth means a six-flit packet uses up all credits within a few cycles, which exposes the credit stall. Eight VCs split into two classes leave spare VCs in each class, so a reserved VC can be seen being skipped and later reused.

// File: rtl/mesh_router_pkg.sv
// Shared constants for the mesh router: port numbering, class count and
// sideband field positions. Assumes the sideband is at least 7 bits wide.
package mesh_router_pkg;
    localparam int NPORT  = 5;
    localparam int PW     = 3;
    localparam int NCLASS = 2;

    localparam logic [PW-1:0] PORT_LOCAL = 3'd0;
    localparam logic [PW-1:0] PORT_EAST  = 3'd1;
    localparam logic [PW-1:0] PORT_WEST  = 3'd2;
    localparam logic [PW-1:0] PORT_NORTH = 3'd3;
    localparam logic [PW-1:0] PORT_SOUTH = 3'd4;

    localparam int SB_TAIL = 0;
    localparam int SB_HEAD = 1;
    localparam int SB_DEST = 2;
endpackage

// File: rtl/vc_fifo.sv
// Flit buffer for one virtual channel. The front entry is visible
// combinationally. Assumes the upstream credit protocol prevents writes
// into a full buffer and the allocator never pops an empty one.
module vc_fifo #(
    parameter int W     = 144,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          full;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    // Storage write, no reset needed.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wp] <= wr_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr_en) wp <= step(wp);
            if (rd_en) rp <= step(rp);
            case ({wr_en, rd_en})
                2'b10:   cnt <= cnt + (AW+1)'(1);
                2'b01:   cnt <= cnt - (AW+1)'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    assign rd_data = mem[rp];
    assign empty   = (cnt == '0);
    assign full    = (cnt == (AW+1)'(DEPTH));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (!full || rd_en));  // R9
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);  // R6
endmodule

// File: rtl/xy_route.sv
// Dimension-ordered route selection: resolve X first, then Y, then deliver
// locally. Assumes Y grows toward north and X grows toward east.
module xy_route
    import mesh_router_pkg::*;
#(
    parameter int COLS = 6,
    parameter int ROWS = 4,
    parameter int MY_X = 2,
    parameter int MY_Y = 1
) (
    input  logic [$clog2(COLS)-1:0] dest_x,
    input  logic [$clog2(ROWS)-1:0] dest_y,
    output logic [PW-1:0]           port
);
    localparam int XW = $clog2(COLS);
    localparam int YW = $clog2(ROWS);

    // Pick the output direction for a head flit.
    always_comb begin
        if (dest_x > XW'(MY_X))      port = PORT_EAST;
        else if (dest_x < XW'(MY_X)) port = PORT_WEST;
        else if (dest_y > YW'(MY_Y)) port = PORT_NORTH;
        else if (dest_y < YW'(MY_Y)) port = PORT_SOUTH;
        else                         port = PORT_LOCAL;
    end
endmodule

// File: rtl/rr_arbiter.sv
// Round-robin arbiter. It grants the first requester at or after the
// pointer, and the pointer moves past the winner. Assumes every grant is
// consumed in the cycle it is given.
module rr_arbiter #(
    parameter int N = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] ptr, win;
    logic          found;

    // Search the requests starting from the pointer position.
    always_comb begin
        gnt   = '0;
        win   = '0;
        found = 1'b0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = int'(ptr) + k;
            if (idx >= N) idx = idx - N;
            if (!found && req[idx]) begin
                gnt[idx] = 1'b1;
                win      = IW'(idx);
                found    = 1'b1;
            end
        end
    end

    // Move the pointer just past the last winner.
    always_ff @(posedge clk) begin
        if (!rst_n)     ptr <= '0;
        else if (found) ptr <= (win == IW'(N - 1)) ? '0 : win + IW'(1);
    end
endmodule

// File: rtl/mesh_router.sv
// Five-port mesh router with per-VC input buffers, X-then-Y routing,
// class-preserving VC allocation, round-robin switch allocation and
// credit flow control. Pipeline stages: buffer write, route plus VC
// allocation, switch allocation, switch traversal. Assumes the upstream
// senders respect the credits returned on crd_ret.
module mesh_router
    import mesh_router_pkg::*;
#(
    parameter int DW    = 128,
    parameter int SBW   = 16,
    parameter int NVC   = 8,
    parameter int DEPTH = 4,
    parameter int COLS  = 6,
    parameter int ROWS  = 4,
    parameter int MY_X  = 2,
    parameter int MY_Y  = 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NPORT-1:0]                    in_valid,
    input  logic [NPORT-1:0][$clog2(NVC)-1:0]   in_vc,
    input  logic [NPORT-1:0][DW-1:0]            in_data,
    input  logic [NPORT-1:0][SBW-1:0]           in_sb,
    output logic [NPORT-1:0][NVC-1:0]           crd_ret,
    output logic [NPORT-1:0]                    out_valid,
    output logic [NPORT-1:0][$clog2(NVC)-1:0]   out_vc,
    output logic [NPORT-1:0][DW-1:0]            out_data,
    output logic [NPORT-1:0][SBW-1:0]           out_sb,
    input  logic [NPORT-1:0][NVC-1:0]           crd_in
);
    localparam int VCW  = $clog2(NVC);
    localparam int XW   = $clog2(COLS);
    localparam int YW   = $clog2(ROWS);
    localparam int W    = DW + SBW;
    localparam int NI   = NPORT * NVC;
    localparam int VPC  = NVC / NCLASS;
    localparam int CNTW = $clog2(DEPTH + 1);

    logic [NI-1:0]                fifo_wr, empty, pop, va_req, va_win;
    logic [NI-1:0][W-1:0]         front;
    logic [NI-1:0][PW-1:0]        rc_port, vc_oport;
    logic [NI-1:0][VCW-1:0]       vc_ovc, va_vc;
    logic [NI-1:0]                vc_active;
    logic [NPORT-1:0][NVC-1:0]    ovc_busy, va_take, ovc_rel;
    logic [NPORT-1:0][NVC-1:0][CNTW-1:0] credit;
    logic [NPORT-1:0][NI-1:0]     sa_req, sa_gnt;
    logic [NPORT-1:0]             sa_valid, sel_cls, st_valid;
    logic [NPORT-1:0][W-1:0]      sel_flit, st_flit;
    logic [NPORT-1:0][VCW-1:0]    sel_vc, st_vc;

    // Stage 1 and route computation: one buffer and one router per input VC.
    for (genvar i = 0; i < NI; i++) begin : g_vc
        localparam int P = i / NVC;
        localparam int V = i % NVC;
        assign fifo_wr[i] = in_valid[P] && (in_vc[P] == VCW'(V));
        assign va_req[i]  = !vc_active[i] && !empty[i] && front[i][DW+SB_HEAD];

        vc_fifo #(.W(W), .DEPTH(DEPTH)) u_buf (
            .clk(clk), .rst_n(rst_n), .wr_en(fifo_wr[i]),
            .wr_data({in_sb[P], in_data[P]}), .rd_en(pop[i]),
            .rd_data(front[i]), .empty(empty[i]));

        xy_route #(.COLS(COLS), .ROWS(ROWS), .MY_X(MY_X), .MY_Y(MY_Y)) u_rc (
            .dest_x(front[i][DW+SB_DEST +: XW]),
            .dest_y(front[i][DW+SB_DEST+XW +: YW]),
            .port(rc_port[i]));
    end

    // Stage 2: one VC grant per output and class, lowest requester and lowest free VC.
    always_comb begin
        va_win  = '0;
        va_vc   = '0;
        va_take = '0;
        for (int o = 0; o < NPORT; o++) begin
            for (int c = 0; c < NCLASS; c++) begin
                int si, sw;
                si = -1;
                sw = -1;
                for (int i = 0; i < NI; i++)
                    if (si < 0 && va_req[i] && rc_port[i] == PW'(o) && (i % NVC) / VPC == c)
                        si = i;
                for (int k = 0; k < VPC; k++)
                    if (sw < 0 && !ovc_busy[o][c*VPC+k]) sw = c * VPC + k;
                if (si >= 0 && sw >= 0) begin
                    va_win[si]     = 1'b1;
                    va_vc[si]      = VCW'(sw);
                    va_take[o][sw] = 1'b1;
                end
            end
        end
    end

    // Stage 3 requests: reserved, holding a flit, and downstream credit available.
    always_comb begin
        for (int o = 0; o < NPORT; o++)
            for (int i = 0; i < NI; i++)
                sa_req[o][i] = vc_active[i] && !empty[i] && vc_oport[i] == PW'(o)
                               && credit[o][vc_ovc[i]] != '0;
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        rr_arbiter #(.N(NI)) u_sa (
            .clk(clk), .rst_n(rst_n), .req(sa_req[o]), .gnt(sa_gnt[o]));

        AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(sa_gnt[o]));  // R10
        AST_VC_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
            sa_valid[o] |-> (sel_cls[o] == (sel_vc[o] >= VCW'(VPC))));  // R5
        AST_CREDIT_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
            sa_valid[o] |-> (credit[o][sel_vc[o]] != '0));  // R8
        AST_VC_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
            sa_valid[o] |-> ovc_busy[o][sel_vc[o]]);  // R7
        for (genvar w = 0; w < NVC; w++) begin : g_cr
            AST_CREDIT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
                credit[o][w] <= CNTW'(DEPTH));  // R8
        end
    end

    // Crossbar select: gather the winning flit, its VC and class, and the pops.
    always_comb begin
        pop      = '0;
        sel_flit = '0;
        sel_vc   = '0;
        sel_cls  = '0;
        ovc_rel  = '0;
        for (int o = 0; o < NPORT; o++) begin
            for (int i = 0; i < NI; i++) begin
                if (sa_gnt[o][i]) begin
                    sel_flit[o] = sel_flit[o] | front[i];
                    sel_vc[o]   = sel_vc[o] | vc_ovc[i];
                    sel_cls[o]  = sel_cls[o] | ((i % NVC) >= VPC);
                    pop[i]      = 1'b1;
                end
            end
            sa_valid[o] = |sa_gnt[o];
            if (sa_valid[o] && sel_flit[o][DW+SB_TAIL]) ovc_rel[o][sel_vc[o]] = 1'b1;
        end
    end

    // Input VC state: reserve on allocation, release when the tail departs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vc_active <= '0;
            vc_oport  <= '0;
            vc_ovc    <= '0;
        end else begin
            for (int i = 0; i < NI; i++) begin
                if (va_win[i]) begin
                    vc_active[i] <= 1'b1;
                    vc_oport[i]  <= rc_port[i];
                    vc_ovc[i]    <= va_vc[i];
                end else if (pop[i] && front[i][DW+SB_TAIL]) begin
                    vc_active[i] <= 1'b0;
                end
            end
        end
    end

    // Downstream VC reservation and credit counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovc_busy <= '0;
            for (int o = 0; o < NPORT; o++)
                for (int w = 0; w < NVC; w++) credit[o][w] <= CNTW'(DEPTH);
        end else begin
            for (int o = 0; o < NPORT; o++) begin
                for (int w = 0; w < NVC; w++) begin
                    if (va_take[o][w])      ovc_busy[o][w] <= 1'b1;
                    else if (ovc_rel[o][w]) ovc_busy[o][w] <= 1'b0;
                    credit[o][w] <= credit[o][w] + CNTW'(crd_in[o][w])
                                  - CNTW'(sa_valid[o] && sel_vc[o] == VCW'(w));
                end
            end
        end
    end

    // Stages 3 and 4: switch allocation register, then traversal register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_valid  <= '0;
            st_flit   <= '0;
            st_vc     <= '0;
            out_valid <= '0;
            out_vc    <= '0;
            out_data  <= '0;
            out_sb    <= '0;
            crd_ret   <= '0;
        end else begin
            st_valid <= sa_valid;
            st_flit  <= sel_flit;
            st_vc    <= sel_vc;
            crd_ret  <= pop;
            for (int o = 0; o < NPORT; o++) begin
                out_valid[o] <= st_valid[o];
                out_vc[o]    <= st_vc[o];
                out_data[o]  <= st_flit[o][DW-1:0];
                out_sb[o]    <= st_flit[o][W-1:DW];
            end
        end
    end
endmodule

// File: tb/test_mesh_router.sv
module test_mesh_router;
    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [4:0]           in_valid = '0;
    logic [4:0][2:0]      in_vc = '0;
    logic [4:0][127:0]    in_data = '0;
    logic [4:0][15:0]     in_sb = '0;
    logic [4:0][7:0]      crd_ret;
    logic [4:0]           out_valid;
    logic [4:0][2:0]      out_vc;
    logic [4:0][127:0]    out_data;
    logic [4:0][15:0]     out_sb;
    logic [4:0][7:0]      crd_in = '0;

    int n_chk = 0;
    int n_bad = 0;

    mesh_router i_mesh_router (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vc(in_vc),
        .in_data(in_data), .in_sb(in_sb), .crd_ret(crd_ret),
        .out_valid(out_valid), .out_vc(out_vc), .out_data(out_data),
        .out_sb(out_sb), .crd_in(crd_in));

    always #2 clk = ~clk;

    // Output log per port, sampled away from the active edge.
    int          mon_n [5];
    logic [15:0] mon_id [5][64];
    logic [2:0]  mon_vc [5][64];
    initial for (int p = 0; p < 5; p++) mon_n[p] = 0;
    always @(negedge clk) begin
        for (int p = 0; p < 5; p++) begin
            if (rst_n && out_valid[p] && mon_n[p] < 64) begin
                mon_id[p][mon_n[p]] = out_data[p][15:0];
                mon_vc[p][mon_n[p]] = out_vc[p];
                mon_n[p] = mon_n[p] + 1;
            end
        end
    end

    // {in port, in vc, dest x, dest y, expected port, expected vc}; router at (2,1).
    localparam logic [16:0] VEC [8] = '{
        {3'd0, 3'd0, 3'd5, 2'd1, 3'd1, 3'd0},
        {3'd0, 3'd5, 3'd0, 2'd3, 3'd2, 3'd4},
        {3'd1, 3'd2, 3'd2, 2'd3, 3'd3, 3'd0},
        {3'd2, 3'd7, 3'd2, 2'd0, 3'd4, 3'd4},
        {3'd3, 3'd1, 3'd2, 2'd1, 3'd0, 3'd0},
        {3'd4, 3'd6, 3'd3, 2'd0, 3'd1, 3'd4},
        {3'd0, 3'd3, 3'd1, 2'd1, 3'd2, 3'd0},
        {3'd2, 3'd4, 3'd4, 2'd3, 3'd1, 3'd4}
    };

    task automatic chk(input string tag, input logic [143:0] act, input logic [143:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] sbv(input logic [15:0] id, input int dx, input int dy,
                                        input bit head, input bit tail);
        return {id[8:0], 2'(dy), 3'(dx), head, tail};
    endfunction

    task automatic drive(input int p, input int v, input logic [15:0] id, input logic [15:0] sb);
        in_valid[p] = 1'b1;
        in_vc[p]    = 3'(v);
        in_data[p]  = {8{id}};
        in_sb[p]    = sb;
    endtask

    task automatic ret_credit(input int o, input int w, input int n);
        for (int k = 0; k < n; k++) begin
            crd_in[o][w] = 1'b1;
            @(negedge clk);
        end
        crd_in[o][w] = 1'b0;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int base;
        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid", 144'(out_valid), 144'd0);
        chk("R1 crd_ret", 144'(crd_ret), 144'd0);

        // Table walk: single-flit packets, one per vector.
        for (int n = 0; n < 8; n++) begin
            int vp, vv, dx, dy, ep, ev;
            logic [15:0] id, sb;
            vp = int'(VEC[n][16:14]); vv = int'(VEC[n][13:11]);
            dx = int'(VEC[n][10:8]);  dy = int'(VEC[n][7:6]);
            ep = int'(VEC[n][5:3]);   ev = int'(VEC[n][2:0]);
            id = 16'h0A00 + 16'(n);
            sb = sbv(id, dx, dy, 1'b1, 1'b1);
            drive(vp, vv, id, sb);
            @(negedge clk);
            in_valid = '0;
            repeat (2) @(negedge clk);
            chk("R4 not yet on output", 144'(out_valid), 144'd0);
            chk("R9 credit pulse", 144'(crd_ret[vp][vv]), 144'd1);
            @(negedge clk);
            chk("R2 R3 output port", 144'(out_valid), 144'(5'b1 << ep));
            chk("R5 output vc", 144'(out_vc[ep]), 144'(ev));
            chk("R11 data", 144'(out_data[ep]), 144'({8{id}}));
            chk("R11 sideband", 144'(out_sb[ep]), 144'(sb));
            ret_credit(ep, ev, 1);
            repeat (2) @(negedge clk);
        end

        // R10: two 3-flit packets from west vc0 and south vc0 both to east.
        base = mon_n[1];
        for (int k = 0; k < 3; k++) begin
            drive(2, 0, 16'h0100 + 16'(k), sbv(16'h0100, 5, 1, k == 0, k == 2));
            drive(4, 0, 16'h0200 + 16'(k), sbv(16'h0200, 5, 1, k == 0, k == 2));
            @(negedge clk);
        end
        in_valid = '0;
        repeat (10) @(negedge clk);
        chk("R10 east count", 144'(mon_n[1] - base), 144'd6);
        for (int k = 0; k < 6; k++) begin
            chk("R10 interleave id", 144'(mon_id[1][base+k]),
                144'((k % 2 == 0) ? 16'h0100 + 16'(k/2) : 16'h0200 + 16'(k/2)));
            chk("R5 R10 vc per packet", 144'(mon_vc[1][base+k]), 144'(k % 2));
        end
        ret_credit(1, 0, 3);
        ret_credit(1, 1, 3);

        // R7: a reserved VC is skipped, then reused after its tail leaves.
        base = mon_n[1];
        drive(0, 0, 16'h0300, sbv(16'h0300, 5, 1, 1'b1, 1'b0));
        @(negedge clk); in_valid = '0; repeat (6) @(negedge clk);
        drive(0, 1, 16'h0301, sbv(16'h0301, 5, 1, 1'b1, 1'b1));
        @(negedge clk); in_valid = '0; repeat (6) @(negedge clk);
        drive(0, 0, 16'h0302, sbv(16'h0302, 0, 0, 1'b0, 1'b1));
        @(negedge clk); in_valid = '0; repeat (6) @(negedge clk);
        drive(0, 2, 16'h0303, sbv(16'h0303, 5, 1, 1'b1, 1'b1));
        @(negedge clk); in_valid = '0; repeat (6) @(negedge clk);
        chk("R7 count", 144'(mon_n[1] - base), 144'd4);
        chk("R7 busy vc skipped", 144'(mon_vc[1][base+1]), 144'd1);
        chk("R6 tail follows head vc", 144'(mon_vc[1][base+2]), 144'd0);
        chk("R7 released vc reused", 144'(mon_vc[1][base+3]), 144'd0);
        ret_credit(1, 0, 3);
        ret_credit(1, 1, 1);

        // R8: six flits on local vc4 to east, no credits back at first.
        base = mon_n[1];
        for (int k = 0; k < 6; k++) begin
            if (k == 0) drive(0, 4, 16'h0400, sbv(16'h0400, 4, 1, 1'b1, 1'b0));
            else        drive(0, 4, 16'h0400 + 16'(k), sbv(16'h0400, 0, 0, 1'b0, k == 5));
            @(negedge clk);
        end
        in_valid = '0;
        repeat (12) @(negedge clk);
        chk("R8 stall after four", 144'(mon_n[1] - base), 144'd4);
        chk("R6 body not sent west", 144'(mon_n[2]), 144'd2);
        ret_credit(1, 4, 6);
        repeat (10) @(negedge clk);
        chk("R8 resumed after credits", 144'(mon_n[1] - base), 144'd6);
        for (int k = 0; k < 6; k++) begin
            chk("R6 order", 144'(mon_id[1][base+k]), 144'(16'h0400 + 16'(k)));
            chk("R6 vc", 144'(mon_vc[1][base+k]), 144'd4);
        end

        // R1: reset while a flit is in flight discards it.
        base = mon_n[1];
        drive(0, 0, 16'h0500, sbv(16'h0500, 5, 1, 1'b1, 1'b1));
        @(negedge clk); in_valid = '0;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 outputs low in reset", 144'({out_valid, crd_ret}), 144'd0);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        chk("R1 flit discarded", 144'(mon_n[1] - base), 144'd0);

        // R1 and R8: after reset, four credits per VC are available again.
        base = mon_n[1];
        for (int k = 0; k < 5; k++) begin
            drive(0, 1, 16'h0600 + 16'(k), sbv(16'h0600, 5, 1, k == 0, k == 4));
            @(negedge clk);
        end
        in_valid = '0;
        repeat (10) @(negedge clk);
        chk("R1 credits full after reset", 144'(mon_n[1] - base), 144'd4);

        summary();
        $finish;
    end
endmodule